// File: doc/BRIEF.md
# Reset Release Sequencer with Cause Flags

This block decides when a processor core may leave reset, and it records why the last reset happened. A power-on pulse or a brown-out pulse starts a release sequence. The first stage is a power-up delay counted in reference-clock cycles, and it runs only when its active-low strap is tied to 0. The second stage is an oscillator start-up delay counted in oscillator strobes, and it runs only when the crystal mode is selected. When both stages are done and the master-clear pin is high, the core run enable goes high.

The oscillator is modelled as a one-cycle strobe `osc_tick_i`, which marks one oscillator period in the reference-clock domain. The block also handles the core's low-power sleep. The core stops when it signals sleep. It resumes on a wake-up event, on a watchdog time-out or on master clear. After a wake-up in crystal mode it first waits out the start-up delay again. Four status flags record the kind of reset, and software can overwrite them.

All ports are plain control and status pins. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `reset_seq_top`

## Requirements
- R1: `run_o` is low while `mclr_n_i` is low, while `por_i` or `bor_i` is high, and while a delay is counting. It goes high at the first rising edge at which none of these holds.
- R2: Power-up timer. With `pwrt_en_n_i`=0 and a non-crystal mode, `run_o` goes high at the PWRT_CYCLES-th rising edge that samples `por_i` and `bor_i` low. This assumes `mclr_n_i` stays high.
- R3: Start-up delay. With `osc_mode_i`=2'b11 (crystal), the block counts OST_TICKS strobes of `osc_tick_i` after the power-up stage ends, and only then raises `run_o`. The other modes are 2'b00 external clock, 2'b01 RC and 2'b10 internal oscillator, and they skip this stage.
- R4: With `pwrt_en_n_i`=1 and a non-crystal mode, `run_o` rises at the first edge that samples `por_i` low.
- R5: Both delays count from the pulse regardless of `mclr_n_i`. If `mclr_n_i` is still low when they expire, `run_o` rises at the first edge that samples `mclr_n_i` high.
- R6: A `sleep_i` pulse while `run_o` is high stops the core. A `wake_i` pulse during sleep resumes it after OST_TICKS strobes in crystal mode, or at the next edge in other modes. The power-up timer never runs on wake-up. `wake_i` has no effect outside sleep.
- R7: A power-on pulse sets the flags as follows. `status_o` is {time-out[3], power-down[2], power-on[1], brown-out[0]}. Time-out becomes 1, power-down becomes 1, power-on becomes 0, and brown-out is defined as 1.
- R8: A brown-out pulse (with `por_i` low) sets time-out to 1, power-down to 1 and brown-out to 0. It leaves power-on unchanged.
- R9: A watchdog time-out while running clears time-out. Power-down and the other flags are unchanged, and `run_o` drops for exactly one cycle.
- R10: A watchdog time-out during sleep clears both time-out and power-down, and it wakes the core as in R6.
- R11: Master clear during run changes no flag. Master clear during sleep clears power-down only, and it ends sleep with no start-up delay.
- R12: `sw_we_i` loads `sw_wdata_i` into `status_o` at the next edge. Any reset or wake event in the same cycle takes precedence over the write.
- R13: A new power-on or brown-out pulse in the middle of a sequence restarts the sequence from the power-up timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| por_i | input | 1 | Power-on pulse; also initialises the block |
| bor_i | input | 1 | Brown-out pulse |
| mclr_n_i | input | 1 | Master clear, active low |
| wdt_to_i | input | 1 | Watchdog time-out strobe |
| sleep_i | input | 1 | Core requests sleep (strobe) |
| wake_i | input | 1 | Wake-up event strobe |
| osc_tick_i | input | 1 | One oscillator period elapsed (strobe) |
| osc_mode_i | input | 2 | Oscillator mode, 2'b11 is crystal |
| pwrt_en_n_i | input | 1 | Power-up timer strap, 0 enables |
| sw_we_i | input | 1 | Software write of the status flags |
| sw_wdata_i | input | 4 | Flag values to write |
| run_o | output | 1 | Core run enable |
| status_o | output | 4 | {time-out, power-down, power-on, brown-out} |

## Verification
A corrupted sequencer state shows at `run_o`. It either rises early, stays low after every release condition has cleared, or misses the one-cycle watchdog dip, and the mismatch appears on the first cycle after the expected edge. A miscounted delay moves the rising edge of `run_o` by whole cycles or strobes. A wrong event decode shows in `status_o` one cycle after the event. The bench keeps a cycle model built from the requirements and compares both outputs on every cycle, so a deviation is reported on the cycle it first appears.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_PWRT   = 3'd0,
    ST_OSTART = 3'd1,
    ST_RUN    = 3'd2,
    ST_SLEEP  = 3'd3,
    ST_WAKE   = 3'd4
  } seq_st_e;

  localparam logic [1:0] OM_EXT  = 2'b00;
  localparam logic [1:0] OM_RC   = 2'b01;
  localparam logic [1:0] OM_INT  = 2'b10;
  localparam logic [1:0] OM_XTAL = 2'b11;

  localparam int STAT_W  = 4;
  localparam int FL_TOUT = 3;
  localparam int FL_PDN  = 2;
  localparam int FL_PON  = 1;
  localparam int FL_BOUT = 0;

  typedef struct packed {
    logic pwr_on;
    logic brown;
    logic wdog_rst;
    logic wdog_wake;
    logic clr_sleep;
  } rst_ev_t;

endpackage

// File: rtl/rsq_tick_cnt.sv
module rsq_tick_cnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (clr_i)       cnt_q <= '0;
    else if (done_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  // R2 / R3: the delay count never passes its terminal value
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (clr_i)
    32'(cnt_q) < LIMIT);

  // R3: a completed count restarts from zero
  a_r3_cnt_wrap: assert property (@(posedge clk_i) disable iff (clr_i)
    done_o |=> (cnt_q == '0));
endmodule

// File: rtl/rsq_status_reg.sv
module rsq_status_reg
  import rsq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  rst_ev_t           ev_i,
  input  logic              sw_we_i,
  input  logic [STAT_W-1:0] sw_wdata_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  always_ff @(posedge clk_i) begin
    if (ev_i.pwr_on) begin
      stat_q[FL_TOUT] <= 1'b1;
      stat_q[FL_PDN]  <= 1'b1;
      stat_q[FL_PON]  <= 1'b0;
      stat_q[FL_BOUT] <= 1'b1;
    end else if (ev_i.brown) begin
      stat_q[FL_TOUT] <= 1'b1;
      stat_q[FL_PDN]  <= 1'b1;
      stat_q[FL_BOUT] <= 1'b0;
    end else if (ev_i.wdog_rst) begin
      stat_q[FL_TOUT] <= 1'b0;
    end else if (ev_i.wdog_wake) begin
      stat_q[FL_TOUT] <= 1'b0;
      stat_q[FL_PDN]  <= 1'b0;
    end else if (ev_i.clr_sleep) begin
      stat_q[FL_PDN]  <= 1'b0;
    end else if (sw_we_i) begin
      stat_q <= sw_wdata_i;
    end
  end

  assign stat_o = stat_q;

  // R7: after power-on ends the flags show the power-on pattern
  a_r7_por_flags: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (stat_q == 4'b1101));

  // R8: brown-out clears its flag and keeps power-on
  a_r8_bor_flags: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_i.brown |=> (!stat_q[FL_BOUT] && stat_q[FL_TOUT] && stat_q[FL_PDN]
                    && $stable(stat_q[FL_PON])));

  // R9: watchdog reset clears time-out, power-down unchanged
  a_r9_wdt_flags: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_i.wdog_rst |=> (!stat_q[FL_TOUT] && $stable(stat_q[FL_PDN])));

  // R11: master clear in sleep touches power-down only
  a_r11_mclr_sleep: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_i.clr_sleep |=> (!stat_q[FL_PDN] && $stable(stat_q[FL_TOUT])
                        && $stable(stat_q[FL_PON])));
endmodule

// File: rtl/rsq_seq_fsm.sv
module rsq_seq_fsm
  import rsq_pkg::*;
(
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       mclr_n_i,
  input  logic       wdt_to_i,
  input  logic       sleep_i,
  input  logic       wake_i,
  input  logic [1:0] osc_mode_i,
  input  logic       pwrt_en_n_i,
  input  logic       pwrt_done_i,
  input  logic       ost_done_i,
  output logic       pwrt_clr_o,
  output logic       ost_clr_o,
  output rst_ev_t    ev_o,
  output logic       run_o
);
  seq_st_e state_q, nxt, entry_st, wake_st;
  logic    run_q, run_d, xtal;

  assign xtal     = (osc_mode_i == OM_XTAL);
  assign wake_st  = xtal ? ST_WAKE : ST_RUN;
  assign entry_st = !pwrt_en_n_i ? ST_PWRT : (xtal ? ST_OSTART : ST_RUN);

  always_comb begin
    nxt  = state_q;
    ev_o = '0;
    if (por_i) begin
      ev_o.pwr_on = 1'b1;
      nxt = entry_st;
    end else if (bor_i) begin
      ev_o.brown = 1'b1;
      nxt = entry_st;
    end else begin
      case (state_q)
        ST_PWRT:
          if (pwrt_done_i) nxt = xtal ? ST_OSTART : ST_RUN;
        ST_OSTART, ST_WAKE:
          if (ost_done_i) nxt = ST_RUN;
        ST_RUN:
          if (mclr_n_i) begin
            if (wdt_to_i)              ev_o.wdog_rst = 1'b1;
            else if (sleep_i && run_q) nxt = ST_SLEEP;
          end
        ST_SLEEP:
          if (!mclr_n_i) begin
            ev_o.clr_sleep = 1'b1;
            nxt = ST_RUN;
          end else if (wdt_to_i) begin
            ev_o.wdog_wake = 1'b1;
            nxt = wake_st;
          end else if (wake_i) begin
            nxt = wake_st;
          end
        default: nxt = entry_st;
      endcase
    end
  end

  assign run_d = (nxt == ST_RUN) && mclr_n_i && !por_i && !bor_i && !ev_o.wdog_rst;

  always_ff @(posedge clk_i) begin
    state_q <= nxt;
    run_q   <= run_d;
  end

  assign pwrt_clr_o = por_i || bor_i || (state_q != ST_PWRT);
  assign ost_clr_o  = por_i || bor_i || !((state_q == ST_OSTART) || (state_q == ST_WAKE));
  assign run_o      = run_q;

  // R6: the core never runs while asleep
  a_r6_sleep_halts: assert property (@(posedge clk_i) disable iff (por_i)
    (state_q == ST_SLEEP) |-> !run_q);

  // R13: a brown-out with the timer strapped on restarts at the timer
  a_r13_restart: assert property (@(posedge clk_i) disable iff (por_i)
    (bor_i && !pwrt_en_n_i) |=> (state_q == ST_PWRT));

  // R1: no run while a delay stage is active
  a_r1_no_run_in_delay: assert property (@(posedge clk_i) disable iff (por_i)
    ((state_q == ST_PWRT) || (state_q == ST_OSTART) || (state_q == ST_WAKE)) |-> !run_q);
endmodule

// File: rtl/reset_seq_top.sv
module reset_seq_top
  import rsq_pkg::*;
#(
  parameter int PWRT_CYCLES = 18000,
  parameter int OST_TICKS   = 1024
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              mclr_n_i,
  input  logic              wdt_to_i,
  input  logic              sleep_i,
  input  logic              wake_i,
  input  logic              osc_tick_i,
  input  logic [1:0]        osc_mode_i,
  input  logic              pwrt_en_n_i,
  input  logic              sw_we_i,
  input  logic [STAT_W-1:0] sw_wdata_i,
  output logic              run_o,
  output logic [STAT_W-1:0] status_o
);
  logic    pwrt_clr, ost_clr, pwrt_done, ost_done;
  rst_ev_t ev;

  rsq_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .bor_i      (bor_i),
    .mclr_n_i   (mclr_n_i),
    .wdt_to_i   (wdt_to_i),
    .sleep_i    (sleep_i),
    .wake_i     (wake_i),
    .osc_mode_i (osc_mode_i),
    .pwrt_en_n_i(pwrt_en_n_i),
    .pwrt_done_i(pwrt_done),
    .ost_done_i (ost_done),
    .pwrt_clr_o (pwrt_clr),
    .ost_clr_o  (ost_clr),
    .ev_o       (ev),
    .run_o      (run_o)
  );

  rsq_tick_cnt #(.LIMIT(PWRT_CYCLES)) u_pwrt_cnt (
    .clk_i (clk_i),
    .clr_i (pwrt_clr),
    .en_i  (1'b1),
    .done_o(pwrt_done)
  );

  rsq_tick_cnt #(.LIMIT(OST_TICKS)) u_ost_cnt (
    .clk_i (clk_i),
    .clr_i (ost_clr),
    .en_i  (osc_tick_i),
    .done_o(ost_done)
  );

  rsq_status_reg u_flags (
    .clk_i     (clk_i),
    .rst_i     (por_i),
    .ev_i      (ev),
    .sw_we_i   (sw_we_i),
    .sw_wdata_i(sw_wdata_i),
    .stat_o    (status_o)
  );

  // R1: run only follows a cycle with master clear high and no pulse
  a_r1_run_needs_clear: assert property (@(posedge clk_i) disable iff (por_i)
    run_o |-> ($past(mclr_n_i) && !$past(por_i) && !$past(bor_i)));

  // R4: no time-out at all without timer and crystal
  a_r4_no_timeout: assert property (@(posedge clk_i) disable iff (por_i)
    ($fell(por_i) && pwrt_en_n_i && $stable(pwrt_en_n_i) && (osc_mode_i != OM_XTAL)
     && $stable(osc_mode_i) && mclr_n_i && !bor_i && !wdt_to_i) |=> run_o);

  // R9: a watchdog reset while running drops run for one cycle
  a_r9_wdt_dip: assert property (@(posedge clk_i) disable iff (por_i)
    (ev.wdog_rst && !bor_i) |=> !run_o);
endmodule

// File: tb/reset_seq_top_bench.sv
module reset_seq_top_bench;
  localparam int PW = 6;
  localparam int OT = 5;

  logic clk = 1'b0;
  logic por = 1'b1, bor = 1'b0, mclr_n = 1'b1, wdt = 1'b0, slp = 1'b0, wak = 1'b0;
  logic tick = 1'b1, strap_n = 1'b1, we = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [3:0] wdata = 4'h0;
  logic run;
  logic [3:0] stat;

  int checks = 0, fails = 0;
  bit done_flag = 0;
  string tag = "R7";

  always #2 clk = ~clk;

  reset_seq_top #(.PWRT_CYCLES(PW), .OST_TICKS(OT)) u_reset_seq_top (
    .clk_i(clk), .por_i(por), .bor_i(bor), .mclr_n_i(mclr_n), .wdt_to_i(wdt),
    .sleep_i(slp), .wake_i(wak), .osc_tick_i(tick), .osc_mode_i(mode),
    .pwrt_en_n_i(strap_n), .sw_we_i(we), .sw_wdata_i(wdata),
    .run_o(run), .status_o(stat)
  );

  // Cycle model built from the requirements: 0 timer, 1 start-up, 2 run, 3 sleep, 4 wake delay
  int m_st = 0, m_pc = 0, m_oc = 0;
  logic m_run = 1'b0;
  logic [3:0] m_stat = 4'h0;

  function automatic int entry_of(logic sn, logic [1:0] md);
    if (!sn) return 0;
    return (md == 2'b11) ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    int ns;
    logic wdr, evt, xt;
    ns = m_st; wdr = 0; evt = 0; xt = (mode == 2'b11);
    if (por) begin
      ns = entry_of(strap_n, mode); m_stat = 4'b1101; m_pc = 0; m_oc = 0;
    end else if (bor) begin
      ns = entry_of(strap_n, mode); m_stat[3] = 1; m_stat[2] = 1; m_stat[0] = 0;
      m_pc = 0; m_oc = 0;
    end else begin
      case (m_st)
        0: begin m_pc++; if (m_pc == PW) begin ns = xt ? 1 : 2; m_oc = 0; m_pc = 0; end end
        1, 4: if (tick) begin m_oc++; if (m_oc == OT) begin ns = 2; m_oc = 0; end end
        2: if (mclr_n) begin
             if (wdt) begin wdr = 1; evt = 1; m_stat[3] = 0; end
             else if (slp && m_run) ns = 3;
           end
        3: if (!mclr_n) begin evt = 1; m_stat[2] = 0; ns = 2; end
           else if (wdt) begin evt = 1; m_stat[3] = 0; m_stat[2] = 0; ns = xt ? 4 : 2; m_oc = 0; end
           else if (wak) begin ns = xt ? 4 : 2; m_oc = 0; end
        default: ;
      endcase
      if (we && !evt) m_stat = wdata;
    end
    m_st  = ns;
    m_run = (ns == 2) && mclr_n && !por && !bor && !wdr;
  end

  task automatic compare();
    checks++;
    if (run !== m_run || stat !== m_stat) begin
      fails++;
      $display("FAIL %s t=%0t run act=%b exp=%b status act=%b exp=%b",
               tag, $time, run, m_run, stat, m_stat);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired run act=hung exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tag = "R7"; cyc(3);
    por = 0; tag = "R4"; cyc(3);
    strap_n = 0; mode = 2'b01; por = 1; tag = "R2"; cyc(2); por = 0; cyc(PW + 3);
    mode = 2'b11; por = 1; tag = "R3"; cyc(2); por = 0; cyc(PW + OT + 4);
    tag = "R1"; mclr_n = 0; cyc(3); mclr_n = 1; cyc(2);
    tag = "R5"; mclr_n = 0; por = 1; cyc(2); por = 0; cyc(PW + OT + 5); mclr_n = 1; cyc(3);
    tag = "R9"; wdt = 1; cyc(1); wdt = 0; cyc(3);
    tag = "R12"; we = 1; wdata = 4'b1010; cyc(1); we = 0; cyc(2);
    we = 1; wdata = 4'b0111; cyc(1); we = 0; cyc(1);
    tag = "R6"; wak = 1; cyc(1); wak = 0; cyc(2);
    slp = 1; cyc(1); slp = 0; cyc(3); wak = 1; cyc(1); wak = 0; cyc(OT + 4);
    mode = 2'b00; slp = 1; cyc(1); slp = 0; cyc(2); wak = 1; cyc(1); wak = 0; cyc(3);
    tag = "R10"; mode = 2'b11; slp = 1; cyc(1); slp = 0; cyc(2); wdt = 1; cyc(1); wdt = 0; cyc(OT + 4);
    tag = "R11"; slp = 1; cyc(1); slp = 0; cyc(2); mclr_n = 0; cyc(2); mclr_n = 1; cyc(2);
    mclr_n = 0; cyc(2); mclr_n = 1; cyc(2);
    tag = "R8"; bor = 1; cyc(2); bor = 0; cyc(PW + OT + 4);
    tag = "R13"; por = 1; cyc(1); por = 0; cyc(3); bor = 1; cyc(1); bor = 0; cyc(PW + OT + 4);
    for (int k = 0; k < 20000; k++) begin
      por   = ($urandom_range(299) == 0);
      bor   = ($urandom_range(249) == 0);
      if ($urandom_range(49) == 0) mclr_n = ~mclr_n;
      wdt   = ($urandom_range(69) == 0);
      slp   = ($urandom_range(29) == 0);
      wak   = ($urandom_range(24) == 0);
      tick  = ($urandom_range(1) == 0);
      we    = ($urandom_range(39) == 0);
      wdata = 4'($urandom);
      if (por) begin mode = 2'($urandom); strap_n = 1'($urandom); end
      cyc(1);
    end
    finish_run();
  end
endmodule